// File: doc/BRIEF.md
# Lane Crossbar Remapper with Identifier-Driven Inverse Map

This block routes a set of logical lane streams, each a parallel word per clock, onto physical output lanes under a map that can be changed at run time. Each physical output lane also reports which logical lane it carries, together with a device identifier that is the same on every lane. The far end reads those identifiers from the link configuration data and uses them to undo the permutation. Board routing can then pick whatever physical order suits the layout.

The transmit half holds a pending map and an active map. A map write is checked first: every physical lane must take its word from a different logical lane. A legal write becomes the pending map. The pending map is copied to the active map on a frame boundary strobe. The crossbar output is registered, so the latency is one cycle.

The receive half takes the per-lane identifiers whenever its configuration strobe is high. From them it builds the inverse map and outputs the words in logical order, also through one register. If the same identifier arrives on two lanes, the receive half raises a flag and keeps its previous inverse map. In a loopback the transmit outputs feed the receive inputs, and the words come back in logical order two cycles later.

Top module: `lane_xbar`

## Requirements
- R1: After reset the active and pending maps are both the identity map. `phy_data` and `rx_out` are zero, `phy_lane_id` reads identity (8'hE4 for 4 lanes), and `map_err` and `rx_id_err` are low.
- R2: The word on physical lane p equals the logical word `tx_data[32*s +: 32]` from the previous clock, where s is the source index for lane p in the map that was active for that word. In `map_wdata` and `phy_lane_id` the source index for physical lane p sits in bits [2p+1:2p].
- R3: With the default identity map, each physical lane carries the logical lane of the same number.
- R4: `phy_lane_id` gives, for each physical lane, the logical lane index of the word it currently carries. `phy_dev_id` gives the constant device identifier (8'h5A by default).
- R5: A map write is rejected if two physical lanes would take the same source. A rejected write sets `map_err` and leaves the pending map unchanged. An accepted write clears `map_err`.
- R6: A new map applies from the word presented with `frame_strobe` onward. Every earlier word uses the previous active map, even after the write has been accepted.
- R7: If a map write and `frame_strobe` fall in the same cycle, that boundary applies the map that was pending before the write. The newly written map waits for the next strobe.
- R8: In the cycle `rx_cfg` is high, the inverse map is rebuilt from `rx_lane_id`. The new inverse map already applies to that cycle's word. Logical output l is the `rx_data` word from the physical lane whose identifier is l, registered for one cycle.
- R9: A duplicate identifier in `rx_lane_id` while `rx_cfg` is high sets `rx_id_err` and keeps the previous inverse map. A configuration with no duplicate clears the flag.
- R10: In loopback, with the receive configuration strobe being the frame strobe delayed by one cycle, `rx_out` returns every logical word in order two cycles after it entered, for any legal map.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_data | input | 128 | Logical lane words, lane l at [32l+31:32l] |
| frame_strobe | input | 1 | Frame boundary; the pending map applies from this word |
| map_wr | input | 1 | Map write enable |
| map_wdata | input | 8 | Source index per physical lane, 2 bits each |
| map_err | output | 1 | Last map write was rejected |
| phy_data | output | 128 | Physical lane words |
| phy_lane_id | output | 8 | Logical lane identifier per physical lane |
| phy_dev_id | output | 8 | Device identifier shared by all lanes |
| rx_data | input | 128 | Received physical lane words |
| rx_lane_id | input | 8 | Received lane identifier per physical lane |
| rx_cfg | input | 1 | Receive configuration strobe |
| rx_id_err | output | 1 | Duplicate identifier seen at the last configuration |
| rx_out | output | 128 | Words restored to logical order |

## Verification
A map write and a frame boundary strobe can arrive in the same clock. The bench provokes this by writing one map while the strobe of a boundary is high. It then judges the physical words and lane identifiers for that cycle against the map that was pending before the write, and expects the new map only after the next strobe. The same loopback run also checks that the receive side follows each change without losing a word.

// File: rtl/lane_xbar.sv
module lane_xbar #(
  parameter int LANES  = 4,
  parameter int WORD_W = 32,
  parameter int DEV_W  = 8,
  parameter logic [DEV_W-1:0] DEV_ID = 8'h5A,
  localparam int IW = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LANES*WORD_W-1:0] tx_data,
  input  logic                    frame_strobe,
  input  logic                    map_wr,
  input  logic [LANES*IW-1:0]     map_wdata,
  output logic                    map_err,
  output logic [LANES*WORD_W-1:0] phy_data,
  output logic [LANES*IW-1:0]     phy_lane_id,
  output logic [DEV_W-1:0]        phy_dev_id,
  input  logic [LANES*WORD_W-1:0] rx_data,
  input  logic [LANES*IW-1:0]     rx_lane_id,
  input  logic                    rx_cfg,
  output logic                    rx_id_err,
  output logic [LANES*WORD_W-1:0] rx_out
);

  function automatic logic [LANES*IW-1:0] ident();
    logic [LANES*IW-1:0] m;
    for (int p = 0; p < LANES; p++) m[p*IW +: IW] = IW'(p);
    return m;
  endfunction

  function automatic logic bad_perm(input logic [LANES*IW-1:0] v);
    logic b;
    b = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      if (int'(v[i*IW +: IW]) >= LANES) b = 1'b1;
      for (int j = i + 1; j < LANES; j++)
        if (v[i*IW +: IW] == v[j*IW +: IW]) b = 1'b1;
    end
    return b;
  endfunction

  function automatic logic [WORD_W-1:0] pick(input logic [LANES*WORD_W-1:0] v,
                                             input logic [IW-1:0] i);
    return v[int'(i)*WORD_W +: WORD_W];
  endfunction

  logic [LANES*IW-1:0] cur_map, nxt_map, sel_map;
  logic                wr_bad;

  assign sel_map     = frame_strobe ? nxt_map : cur_map;
  assign wr_bad      = bad_perm(map_wdata);
  assign phy_lane_id = cur_map;
  assign phy_dev_id  = DEV_ID;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_map  <= ident();
      nxt_map  <= ident();
      map_err  <= 1'b0;
      phy_data <= '0;
    end else begin
      cur_map <= sel_map;
      if (map_wr) begin
        map_err <= wr_bad;
        if (!wr_bad) nxt_map <= map_wdata;
      end
      for (int p = 0; p < LANES; p++)
        phy_data[p*WORD_W +: WORD_W] <= pick(tx_data, sel_map[p*IW +: IW]);
    end
  end

  logic [LANES*IW-1:0] inv, inv_new, rx_sel;
  logic                rx_bad;

  always_comb begin
    inv_new = '0;
    for (int p = 0; p < LANES; p++)
      inv_new[int'(rx_lane_id[p*IW +: IW])*IW +: IW] = IW'(p);
  end

  assign rx_bad = bad_perm(rx_lane_id);
  assign rx_sel = (rx_cfg && !rx_bad) ? inv_new : inv;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inv       <= ident();
      rx_id_err <= 1'b0;
      rx_out    <= '0;
    end else begin
      inv <= rx_sel;
      if (rx_cfg) rx_id_err <= rx_bad;
      for (int l = 0; l < LANES; l++)
        rx_out[l*WORD_W +: WORD_W] <= pick(rx_data, rx_sel[l*IW +: IW]);
    end
  end

  // R2: each physical word is last cycle's logical word named by its lane id
  for (genvar g = 0; g < LANES; g++) begin : g_lat
    a_r2_one_cycle_route: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> phy_data[g*WORD_W +: WORD_W] == pick($past(tx_data), phy_lane_id[g*IW +: IW]));
  end

  a_r4_ids_distinct: assert property (@(posedge clk) disable iff (!rst_n)
    !bad_perm(phy_lane_id));

  a_r5_reject_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (map_wr && bad_perm(map_wdata)) |=> (map_err && $stable(nxt_map)));

  a_r6_map_only_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_strobe |=> $stable(phy_lane_id));

  a_r9_dup_keeps_inverse: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cfg && bad_perm(rx_lane_id)) |=> (rx_id_err && $stable(inv)));

endmodule

// File: tb/lane_xbar_test.sv
module lane_xbar_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [127:0] tx_data = '0;
  logic         frame_strobe = 1'b0, map_wr = 1'b0;
  logic [7:0]   map_wdata = '0;
  logic         map_err, rx_id_err;
  logic [127:0] phy_data, rx_out, rx_data;
  logic [7:0]   phy_lane_id, phy_dev_id, rx_lane_id;
  logic         rx_cfg, cfg_q;
  logic         lb = 1'b1;
  logic [127:0] rx_data_d = '0;
  logic [7:0]   rx_id_d = '0;
  logic         rx_cfg_d = 1'b0;
  int checks = 0, errors = 0;
  bit done = 0;

  always_ff @(posedge clk) cfg_q <= rst_n ? frame_strobe : 1'b0;
  assign rx_data    = lb ? phy_data : rx_data_d;
  assign rx_lane_id = lb ? phy_lane_id : rx_id_d;
  assign rx_cfg     = lb ? cfg_q : rx_cfg_d;

  lane_xbar uut (
    .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .frame_strobe(frame_strobe),
    .map_wr(map_wr), .map_wdata(map_wdata), .map_err(map_err),
    .phy_data(phy_data), .phy_lane_id(phy_lane_id), .phy_dev_id(phy_dev_id),
    .rx_data(rx_data), .rx_lane_id(rx_lane_id), .rx_cfg(rx_cfg),
    .rx_id_err(rx_id_err), .rx_out(rx_out));

  function automatic logic [31:0] word(int seq, int l);
    return 32'hC0DE0000 | 32'(seq << 4) | 32'(l);
  endfunction
  function automatic logic [127:0] mk(int seq);
    logic [127:0] v;
    for (int l = 0; l < 4; l++) v[l*32 +: 32] = word(seq, l);
    return v;
  endfunction
  function automatic logic [127:0] phys(int seq, logic [7:0] m);
    logic [127:0] v;
    for (int p = 0; p < 4; p++) v[p*32 +: 32] = word(seq, int'(m[p*2 +: 2]));
    return v;
  endfunction

  task automatic check(input logic ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int seq, input logic fs, input logic wr, input logic [7:0] wm);
    @(negedge clk);
    tx_data = mk(seq); frame_strobe = fs; map_wr = wr; map_wdata = wm;
    @(posedge clk); #1;
    frame_strobe = 1'b0; map_wr = 1'b0;
  endtask

  task automatic chk_phy(input int seq, input logic [7:0] m, input string tag);
    check(phy_data == phys(seq, m), tag, phy_data, phys(seq, m));
    check(phy_lane_id == m, "R4 lane id", {120'd0, phy_lane_id}, {120'd0, m});
  endtask

  task automatic chk_rx(input int seq, input string tag);
    check(rx_out == mk(seq), tag, rx_out, mk(seq));
  endtask

  task automatic t_reset;
    check(phy_data == '0, "R1 phy_data", phy_data, '0);
    check(rx_out == '0, "R1 rx_out", rx_out, '0);
    check(phy_lane_id == 8'hE4, "R1 lane ids", {120'd0, phy_lane_id}, 128'hE4);
    check(!map_err && !rx_id_err, "R1 flags", {126'd0, map_err, rx_id_err}, '0);
    check(phy_dev_id == 8'h5A, "R4 device id", {120'd0, phy_dev_id}, 128'h5A);
  endtask

  task automatic t_identity;
    cyc(1, 0, 0, 0); chk_phy(1, 8'hE4, "R3 identity");
    cyc(2, 0, 0, 0); chk_phy(2, 8'hE4, "R3 identity"); chk_rx(1, "R10 identity loop");
  endtask

  task automatic t_remap;
    cyc(10, 0, 1, 8'h1B); chk_phy(10, 8'hE4, "R6 before boundary");
    check(!map_err, "R5 good write", {127'd0, map_err}, '0);
    cyc(11, 0, 0, 0); chk_phy(11, 8'hE4, "R6 still old map");
    cyc(12, 1, 0, 0); chk_phy(12, 8'h1B, "R2 R6 new map at strobe"); chk_rx(11, "R10 loop");
    cyc(13, 0, 0, 0); chk_phy(13, 8'h1B, "R2 reversed"); chk_rx(12, "R8 rx follows ids");
    cyc(14, 0, 0, 0); chk_rx(13, "R10 loop reversed");
  endtask

  task automatic t_bad;
    cyc(20, 0, 1, 8'h1F);
    check(map_err, "R5 dup write flagged", {127'd0, map_err}, 128'd1);
    cyc(21, 1, 0, 0); chk_phy(21, 8'h1B, "R5 pending kept");
    cyc(22, 0, 1, 8'h4E);
    check(!map_err, "R5 flag cleared", {127'd0, map_err}, '0);
    chk_rx(21, "R10 loop");
  endtask

  task automatic t_collide;
    cyc(30, 1, 1, 8'h93); chk_phy(30, 8'h4E, "R7 boundary uses old pending");
    cyc(31, 0, 0, 0); chk_phy(31, 8'h4E, "R7 held"); chk_rx(30, "R10 loop");
    cyc(32, 1, 0, 0); chk_phy(32, 8'h93, "R7 next boundary"); chk_rx(31, "R10 loop");
    cyc(33, 0, 0, 0); chk_phy(33, 8'h93, "R2 rotated"); chk_rx(32, "R10 loop after change");
  endtask

  task automatic rx_step(input int seq, input logic [7:0] dmap, input logic [7:0] ids, input logic cf);
    @(negedge clk);
    rx_data_d = phys(seq, dmap); rx_id_d = ids; rx_cfg_d = cf;
    @(posedge clk); #1;
    rx_cfg_d = 1'b0;
  endtask

  task automatic t_rxdup;
    lb = 1'b0;
    rx_step(40, 8'h1B, 8'h1B, 1); chk_rx(40, "R8 direct config");
    check(!rx_id_err, "R9 clean", {127'd0, rx_id_err}, '0);
    rx_step(41, 8'h1B, 8'h1F, 1);
    check(rx_id_err, "R9 dup flagged", {127'd0, rx_id_err}, 128'd1);
    chk_rx(41, "R9 inverse kept");
    rx_step(42, 8'h1B, 8'h1F, 0); chk_rx(42, "R9 no cfg no change");
    check(rx_id_err, "R9 flag held", {127'd0, rx_id_err}, 128'd1);
    rx_step(43, 8'hE4, 8'hE4, 1); chk_rx(43, "R8 reconfig");
    check(!rx_id_err, "R9 flag cleared", {127'd0, rx_id_err}, '0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    t_reset;
    t_identity;
    t_remap;
    t_bad;
    t_collide;
    t_rxdup;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R1-timeout act=running exp=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule